// File: doc/BRIEF.md
# Configuration and Window Routing Controller

This block sits between a single host request port and a set of device slots. It accepts one host request at a time and handles it by space type. A configuration request is split into device, function and register fields and sent to the matching slot. A memory or I/O request goes to the slot whose address window claims the address. The block stalls the host until that slot acknowledges or a timeout counter runs out.

Software finds out what is present by issuing configuration reads. A read to a slot or function that is not present never reaches the slots and returns all-ones. A write to one is quietly dropped. Each slot's presence mask and address window are inputs, so whatever holds the programmed values stays outside this block.

Top module: `cfg_bar_router`

## Requirements
- R1: A configuration request (reqKind 2) decodes reqAddr[15:11] as the device number, reqAddr[10:8] as the function number and reqAddr[7:0] as the register offset. The request goes to slot number equal to the device number, and slotFunc and slotReg carry the function and register fields.
- R2: Function f of slot d counts as present only when slotPresent[d*8] (function 0) and slotPresent[d*8+f] are both 1, and d is less than NUM_SLOTS. A configuration read to anything absent drives no slotSel bit and returns 32'hFFFFFFFF.
- R3: A configuration write to an absent device or function drives no slotSel bit, is dropped, and still completes with rspValid.
- R4: A memory request (reqKind 0) goes to a slot whose winIo bit is 0, and an I/O request (reqKind 1) goes to a slot whose winIo bit is 1. In both cases the slot is chosen only when winBase <= address <= winLimit, with both bounds inclusive.
- R5: I/O requests compare and forward only reqAddr[15:0]. The upper bits are ignored, and slotAddr carries them as zero.
- R6: When several windows claim an address, the lowest-numbered slot is selected.
- R7: A memory or I/O request that no window claims, or that uses reqKind 3, completes with 32'hFFFFFFFF. Counting the accepting edge as edge 0, rspValid rises after edge TIMEOUT+1.
- R8: A selected slot that does not acknowledge within TIMEOUT cycles is deselected. The request completes with 32'hFFFFFFFF at the same latency as R7.
- R9: slotKind carries the request's space type unchanged. The encoding is 0 memory, 1 I/O, 2 configuration.
- R10: Only one request is outstanding at a time. reqReady is low from the accepting edge until the cycle after the single-cycle rspValid pulse.
- R11: At most one slotSel bit is high at a time. An acknowledge from the selected slot ends the request, with rspRdata equal to that slot's slotRdata. With an immediate acknowledge, rspValid rises after edge 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Host request accepted when high with reqValid |
| reqKind | input | 2 | Space type: 0 memory, 1 I/O, 2 configuration |
| reqAddr | input | ADDR_W | Request address |
| reqWrite | input | 1 | 1 for write |
| reqWdata | input | DATA_W | Write data |
| reqBe | input | DATA_W/8 | Byte enables |
| rspValid | output | 1 | Single-cycle completion pulse |
| rspRdata | output | DATA_W | Read result |
| slotPresent | input | NUM_SLOTS*8 | Per-slot function presence masks |
| winBase | input | NUM_SLOTS*ADDR_W | Per-slot window lower bound |
| winLimit | input | NUM_SLOTS*ADDR_W | Per-slot window upper bound |
| winIo | input | NUM_SLOTS | Window is in I/O space when 1 |
| slotSel | output | NUM_SLOTS | One-hot slot select |
| slotKind | output | 2 | Space type passed to the slot |
| slotAddr | output | ADDR_W | Forwarded address |
| slotFunc | output | 3 | Function number |
| slotReg | output | 8 | Register offset |
| slotWrite | output | 1 | Forwarded write flag |
| slotWdata | output | DATA_W | Forwarded write data |
| slotBe | output | DATA_W/8 | Forwarded byte enables |
| slotAck | input | NUM_SLOTS | Per-slot acknowledge |
| slotRdata | input | DATA_W | Read data from the acknowledging slot |

## Verification
Some properties are checked on every cycle:
- At most one slot is selected.
- A configuration select only ever targets a slot whose function 0 and requested function are present.
- A memory or I/O select only targets a slot whose window covers the forwarded address.
- An acknowledge is followed by a one-cycle response carrying that slot's data.
- The busy period never exceeds the timeout bound.

Other behaviour only the bench's scenarios can show. This covers the exact field decode, priority among overlapping windows, masking of the upper I/O bits, dropped writes to absent functions, and the fixed latencies of the hit, absent and timeout paths.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;
  localparam int FN_PER_SLOT = 8;
  localparam int IO_W        = 16;

  typedef enum logic [1:0] {
    KIND_MEM = 2'd0,
    KIND_IO  = 2'd1,
    KIND_CFG = 2'd2,
    KIND_RSV = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ROUTE, ST_SLOT, ST_WAIT, ST_DONE
  } state_e;

  // Control strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;
    logic cntClr;
    logic cntInc;
    logic selOn;
    logic loadSlot;
    logic loadOnes;
  } ctl_strobe_t;

  // Status returned from the datapath
  typedef struct packed {
    logic hit;
    logic isCfg;
    logic cntDone;
    logic ackSeen;
  } dp_status_t;
endpackage

// File: rtl/cfg_route_dp.sv
module cfg_route_dp
  import cfg_route_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int TIMEOUT   = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ctl_strobe_t                    st,
  output dp_status_t                     sts,
  input  logic [1:0]                     reqKind,
  input  logic [ADDR_W-1:0]              reqAddr,
  input  logic                           reqWrite,
  input  logic [DATA_W-1:0]              reqWdata,
  input  logic [DATA_W/8-1:0]            reqBe,
  input  logic [NUM_SLOTS*FN_PER_SLOT-1:0] slotPresent,
  input  logic [NUM_SLOTS*ADDR_W-1:0]    winBase,
  input  logic [NUM_SLOTS*ADDR_W-1:0]    winLimit,
  input  logic [NUM_SLOTS-1:0]           winIo,
  input  logic [NUM_SLOTS-1:0]           slotAck,
  input  logic [DATA_W-1:0]              slotRdata,
  output logic [NUM_SLOTS-1:0]           slotSel,
  output logic [1:0]                     slotKind,
  output logic [ADDR_W-1:0]              slotAddr,
  output logic [2:0]                     slotFunc,
  output logic [7:0]                     slotReg,
  output logic                           slotWrite,
  output logic [DATA_W-1:0]              slotWdata,
  output logic [DATA_W/8-1:0]            slotBe,
  output logic [DATA_W-1:0]              rspRdata
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam int BE_W  = DATA_W / 8;

  logic [1:0]        kindQ;
  logic [ADDR_W-1:0] addrQ;
  logic              writeQ;
  logic [DATA_W-1:0] wdataQ;
  logic [BE_W-1:0]   beQ;
  logic [CNT_W-1:0]  cntQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kindQ  <= '0;
      addrQ  <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
      beQ    <= '0;
    end else if (st.capture) begin
      kindQ  <= reqKind;
      addrQ  <= reqAddr;
      writeQ <= reqWrite;
      wdataQ <= reqWdata;
      beQ    <= reqBe;
    end
  end

  logic [4:0] devNum;
  logic [2:0] funcNum;
  logic       isMem, isIo, isCfg;
  logic [ADDR_W-1:0] cmpAddr;

  assign devNum  = addrQ[15:11];
  assign funcNum = addrQ[10:8];
  assign isMem   = kindQ == KIND_MEM;
  assign isIo    = kindQ == KIND_IO;
  assign isCfg   = kindQ == KIND_CFG;
  assign cmpAddr = isIo ? {{(ADDR_W-IO_W){1'b0}}, addrQ[IO_W-1:0]} : addrQ;

  logic [NUM_SLOTS-1:0] cfgHit, winHit;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic [FN_PER_SLOT-1:0] presRow;
    logic [ADDR_W-1:0]      lo, hi;
    logic                   kindOk;
    assign presRow   = slotPresent[i*FN_PER_SLOT +: FN_PER_SLOT];
    assign lo        = winBase[i*ADDR_W +: ADDR_W];
    assign hi        = winLimit[i*ADDR_W +: ADDR_W];
    assign kindOk    = (isMem && !winIo[i]) || (isIo && winIo[i]);
    assign cfgHit[i] = (devNum == 5'(i)) && presRow[0] && presRow[funcNum];
    assign winHit[i] = kindOk && (cmpAddr >= lo) && (cmpAddr <= hi);
  end

  // Lowest-numbered claiming window wins
  logic [NUM_SLOTS-1:0] winPick;
  always_comb begin
    winPick = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (winHit[i]) winPick = NUM_SLOTS'(1) << i;
    end
  end

  logic [NUM_SLOTS-1:0] hitVec;
  assign hitVec = isCfg ? cfgHit : winPick;

  always_ff @(posedge clk) begin
    if (!rstN)          cntQ <= '0;
    else if (st.cntClr) cntQ <= '0;
    else if (st.cntInc) cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            rdataQ <= '0;
    else if (st.loadSlot) rdataQ <= slotRdata;
    else if (st.loadOnes) rdataQ <= '1;
  end

  assign sts.hit     = |hitVec;
  assign sts.isCfg   = isCfg;
  assign sts.cntDone = cntQ == CNT_W'(TIMEOUT - 1);
  assign sts.ackSeen = |(slotAck & hitVec);

  assign slotSel   = st.selOn ? hitVec : '0;
  assign slotKind  = kindQ;
  assign slotAddr  = cmpAddr;
  assign slotFunc  = funcNum;
  assign slotReg   = addrQ[7:0];
  assign slotWrite = writeQ;
  assign slotWdata = wdataQ;
  assign slotBe    = beQ;
  assign rspRdata  = rdataQ;
endmodule

// File: rtl/cfg_route_ctl.sv
module cfg_route_ctl
  import cfg_route_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  dp_status_t  sts,
  output ctl_strobe_t st,
  output logic        reqReady,
  output logic        rspValid
);
  state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    st     = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          st.capture = 1'b1;
          stateD     = ST_ROUTE;
        end
      end
      ST_ROUTE: begin
        st.cntClr = 1'b1;
        if (sts.hit)        stateD = ST_SLOT;
        else if (sts.isCfg) begin
          st.loadOnes = 1'b1;
          stateD      = ST_DONE;
        end else            stateD = ST_WAIT;
      end
      ST_SLOT: begin
        st.selOn = 1'b1;
        if (sts.ackSeen) begin
          st.loadSlot = 1'b1;
          stateD      = ST_DONE;
        end else if (sts.cntDone) begin
          st.loadOnes = 1'b1;
          stateD      = ST_DONE;
        end else st.cntInc = 1'b1;
      end
      ST_WAIT: begin
        if (sts.cntDone) begin
          st.loadOnes = 1'b1;
          stateD      = ST_DONE;
        end else st.cntInc = 1'b1;
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  assign reqReady = stateQ == ST_IDLE;
  assign rspValid = stateQ == ST_DONE;
endmodule

// File: rtl/cfg_bar_router.sv
module cfg_bar_router
  import cfg_route_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int TIMEOUT   = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             reqValid,
  output logic                             reqReady,
  input  logic [1:0]                       reqKind,
  input  logic [ADDR_W-1:0]                reqAddr,
  input  logic                             reqWrite,
  input  logic [DATA_W-1:0]                reqWdata,
  input  logic [DATA_W/8-1:0]              reqBe,
  output logic                             rspValid,
  output logic [DATA_W-1:0]                rspRdata,
  input  logic [NUM_SLOTS*8-1:0]           slotPresent,
  input  logic [NUM_SLOTS*ADDR_W-1:0]      winBase,
  input  logic [NUM_SLOTS*ADDR_W-1:0]      winLimit,
  input  logic [NUM_SLOTS-1:0]             winIo,
  output logic [NUM_SLOTS-1:0]             slotSel,
  output logic [1:0]                       slotKind,
  output logic [ADDR_W-1:0]                slotAddr,
  output logic [2:0]                       slotFunc,
  output logic [7:0]                       slotReg,
  output logic                             slotWrite,
  output logic [DATA_W-1:0]                slotWdata,
  output logic [DATA_W/8-1:0]              slotBe,
  input  logic [NUM_SLOTS-1:0]             slotAck,
  input  logic [DATA_W-1:0]                slotRdata
);
  ctl_strobe_t st;
  dp_status_t  sts;

  cfg_route_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .sts      (sts),
    .st       (st),
    .reqReady (reqReady),
    .rspValid (rspValid)
  );

  cfg_route_dp #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .TIMEOUT   (TIMEOUT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .st          (st),
    .sts         (sts),
    .reqKind     (reqKind),
    .reqAddr     (reqAddr),
    .reqWrite    (reqWrite),
    .reqWdata    (reqWdata),
    .reqBe       (reqBe),
    .slotPresent (slotPresent),
    .winBase     (winBase),
    .winLimit    (winLimit),
    .winIo       (winIo),
    .slotAck     (slotAck),
    .slotRdata   (slotRdata),
    .slotSel     (slotSel),
    .slotKind    (slotKind),
    .slotAddr    (slotAddr),
    .slotFunc    (slotFunc),
    .slotReg     (slotReg),
    .slotWrite   (slotWrite),
    .slotWdata   (slotWdata),
    .slotBe      (slotBe),
    .rspRdata    (rspRdata)
  );
endmodule

// File: rtl/cfg_bar_router_chk.sv
module cfg_bar_router_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int TIMEOUT   = 16
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        reqReady,
  input logic                        rspValid,
  input logic [DATA_W-1:0]           rspRdata,
  input logic [NUM_SLOTS*8-1:0]      slotPresent,
  input logic [NUM_SLOTS*ADDR_W-1:0] winBase,
  input logic [NUM_SLOTS*ADDR_W-1:0] winLimit,
  input logic [NUM_SLOTS-1:0]        slotSel,
  input logic [1:0]                  slotKind,
  input logic [ADDR_W-1:0]           slotAddr,
  input logic [2:0]                  slotFunc,
  input logic [NUM_SLOTS-1:0]        slotAck,
  input logic [DATA_W-1:0]           slotRdata
);
  logic presOk, winOk;
  always_comb begin
    presOk = 1'b0;
    winOk  = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slotSel[i]) begin
        presOk = slotPresent[i*8] && slotPresent[i*8 + int'(slotFunc)];
        winOk  = (slotAddr >= winBase[i*ADDR_W +: ADDR_W]) &&
                 (slotAddr <= winLimit[i*ADDR_W +: ADDR_W]);
      end
    end
  end

  int busyCnt;
  always_ff @(posedge clk) begin
    if (!rstN)         busyCnt <= 0;
    else if (reqReady) busyCnt <= 0;
    else               busyCnt <= busyCnt + 1;
  end

  assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(slotSel));

  assert_ack_data_R11: assert property (@(posedge clk) disable iff (!rstN)
    (|(slotSel & slotAck)) |=> (rspValid && rspRdata == $past(slotRdata)));

  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  assert_busy_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid || (|slotSel)) |-> !reqReady);

  assert_cfg_present_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((|slotSel) && slotKind == 2'd2) |-> presOk);

  assert_window_claim_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((|slotSel) && slotKind != 2'd2) |-> winOk);

  assert_busy_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= TIMEOUT + 2);
endmodule

bind cfg_bar_router cfg_bar_router_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .TIMEOUT   (TIMEOUT)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqReady    (reqReady),
  .rspValid    (rspValid),
  .rspRdata    (rspRdata),
  .slotPresent (slotPresent),
  .winBase     (winBase),
  .winLimit    (winLimit),
  .slotSel     (slotSel),
  .slotKind    (slotKind),
  .slotAddr    (slotAddr),
  .slotFunc    (slotFunc),
  .slotAck     (slotAck),
  .slotRdata   (slotRdata)
);

// File: tb/cfg_bar_router_tb.sv
module cfg_bar_router_tb;
  localparam int NS = 4;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int TO = 16;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic              reqValid = 1'b0, reqReady, reqWrite = 1'b0;
  logic [1:0]        reqKind = '0;
  logic [AW-1:0]     reqAddr = '0;
  logic [DW-1:0]     reqWdata = '0;
  logic [DW/8-1:0]   reqBe = '0;
  logic              rspValid;
  logic [DW-1:0]     rspRdata;
  logic [NS*8-1:0]   slotPresent;
  logic [NS*AW-1:0]  winBase, winLimit;
  logic [NS-1:0]     winIo;
  logic [NS-1:0]     slotSel, slotAck;
  logic [1:0]        slotKind;
  logic [AW-1:0]     slotAddr;
  logic [2:0]        slotFunc;
  logic [7:0]        slotReg;
  logic              slotWrite;
  logic [DW-1:0]     slotWdata, slotRdata;
  logic [DW/8-1:0]   slotBe;
  logic [NS-1:0]     ackEn = 4'b0111;

  cfg_bar_router #(.NUM_SLOTS(NS), .ADDR_W(AW), .DATA_W(DW), .TIMEOUT(TO)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqAddr(reqAddr), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .reqBe(reqBe), .rspValid(rspValid), .rspRdata(rspRdata),
    .slotPresent(slotPresent), .winBase(winBase), .winLimit(winLimit), .winIo(winIo),
    .slotSel(slotSel), .slotKind(slotKind), .slotAddr(slotAddr), .slotFunc(slotFunc),
    .slotReg(slotReg), .slotWrite(slotWrite), .slotWdata(slotWdata), .slotBe(slotBe),
    .slotAck(slotAck), .slotRdata(slotRdata));

  // Slot model: ack at once when enabled, data tagged with slot, function, register
  always_comb begin
    int idx;
    idx = 0;
    for (int i = 0; i < NS; i++) if (slotSel[i]) idx = i;
    slotAck   = slotSel & ackEn;
    slotRdata = 32'hC0DE_0000 | (32'(idx) << 12) | {21'd0, slotFunc, slotReg};
  end

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic        wr;
    logic [7:0]  expSel;   // 8'hFF: no slot selected
    logic [31:0] expData;
    logic [7:0]  expLat;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 32'h0000_0000, 1'b0, 8'd0,   32'hC0DE_0000, 8'd3,  4'd1},  // R1 dev0 fn0
    '{2'd2, 32'h0000_0110, 1'b0, 8'd0,   32'hC0DE_0110, 8'd3,  4'd1},  // R1 dev0 fn1 reg10
    '{2'd2, 32'h0000_0200, 1'b0, 8'hFF,  ONES,          8'd2,  4'd2},  // R2 fn2 absent
    '{2'd2, 32'h0000_0804, 1'b0, 8'd1,   32'hC0DE_1004, 8'd3,  4'd1},  // R1 dev1
    '{2'd2, 32'h0000_1300, 1'b0, 8'hFF,  ONES,          8'd2,  4'd2},  // R2 fn3 without fn0
    '{2'd2, 32'h0000_3800, 1'b0, 8'hFF,  ONES,          8'd2,  4'd2},  // R2 dev7 beyond slots
    '{2'd2, 32'h0000_1800, 1'b1, 8'hFF,  32'h0,         8'd2,  4'd3},  // R3 write absent dev3
    '{2'd0, 32'h1000_0040, 1'b0, 8'd0,   32'hC0DE_0040, 8'd3,  4'd4},  // R4 mem slot0
    '{2'd0, 32'h1000_8123, 1'b0, 8'd0,   32'hC0DE_0123, 8'd3,  4'd6},  // R6 overlap
    '{2'd0, 32'h1001_0000, 1'b0, 8'd1,   32'hC0DE_1000, 8'd3,  4'd4},  // R4 mem slot1
    '{2'd1, 32'h0000_0310, 1'b0, 8'd2,   32'hC0DE_2310, 8'd3,  4'd4},  // R4 io slot2
    '{2'd1, 32'hABCD_0310, 1'b0, 8'd2,   32'hC0DE_2310, 8'd3,  4'd5},  // R5 upper ignored
    '{2'd0, 32'h0000_0310, 1'b0, 8'hFF,  ONES,          8'd18, 4'd7},  // R7 mem in io range
    '{2'd0, 32'h2000_0010, 1'b0, 8'd3,   ONES,          8'd18, 4'd8},  // R8 slot3 silent
    '{2'd0, 32'h1001_0004, 1'b1, 8'd1,   32'h0,         8'd3,  4'd9},  // R9 mem write
    '{2'd1, 32'h0000_0400, 1'b0, 8'hFF,  ONES,          8'd18, 4'd7}   // R7 io unclaimed
  };

  task automatic doReq(input logic [1:0] k, input logic [31:0] a, input logic w,
                       output logic [31:0] rd, output int selIdx,
                       output logic [1:0] kSeen, output logic [31:0] aSeen,
                       output int lat);
    selIdx = -1; kSeen = '0; aSeen = '0; lat = 0;
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqAddr = a; reqWrite = w;
    reqWdata = 32'h5A5A_0000 ^ a; reqBe = 4'hF;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!rspValid && lat < 100) begin
      for (int i = 0; i < NS; i++) if (slotSel[i]) selIdx = i;
      if (|slotSel) begin kSeen = slotKind; aSeen = slotAddr; end
      @(negedge clk);
      lat++;
    end
    rd = rspRdata;
  endtask

  initial begin
    slotPresent = {8'h00, 8'h08, 8'h01, 8'h03};
    winIo       = 4'b0100;
    winBase     = {32'h2000_0000, 32'h0000_0300, 32'h1000_8000, 32'h1000_0000};
    winLimit    = {32'h2000_00FF, 32'h0000_03FF, 32'h1001_FFFF, 32'h1000_FFFF};
    repeat (3) @(negedge clk);
    // Reset state
    check("R10", "reqReady in reset", 32'(reqReady), 32'd1);
    check("R10", "rspValid in reset", 32'(rspValid), 32'd0);
    check("R11", "slotSel in reset", 32'(slotSel), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] rd, aSeen;
      logic [1:0]  kSeen;
      int          selIdx, lat;
      string       tg;
      tg = $sformatf("R%0d vec%0d", VECS[v].tag, v);
      doReq(VECS[v].kind, VECS[v].addr, VECS[v].wr, rd, selIdx, kSeen, aSeen, lat);
      check(tg, "slot", 32'(selIdx),
            VECS[v].expSel == 8'hFF ? 32'hFFFF_FFFF : 32'(VECS[v].expSel));
      check(tg, "latency", 32'(lat), 32'(VECS[v].expLat));
      if (!VECS[v].wr) check(tg, "rdata", rd, VECS[v].expData);
      if (VECS[v].expSel != 8'hFF)
        check("R9", "kind passthrough", 32'(kSeen), 32'(VECS[v].kind));
      if (VECS[v].kind == 2'd1 && VECS[v].expSel != 8'hFF)
        check("R5", "io slotAddr", aSeen, {16'h0, VECS[v].addr[15:0]});
    end

    // R10: ready returns one cycle after the response pulse, which lasts one cycle
    begin
      logic [31:0] rd, aSeen; logic [1:0] kSeen; int selIdx, lat;
      doReq(2'd2, 32'h0, 1'b0, rd, selIdx, kSeen, aSeen, lat);
      check("R10", "ready during rsp", 32'(reqReady), 32'd0);
      @(negedge clk);
      check("R10", "rsp single cycle", 32'(rspValid), 32'd0);
      check("R10", "ready after rsp", 32'(reqReady), 32'd1);
    end

    // R2: removing function 0 of slot1 makes it absent
    begin
      logic [31:0] rd, aSeen; logic [1:0] kSeen; int selIdx, lat;
      slotPresent[8] = 1'b0;
      doReq(2'd2, 32'h0000_0804, 1'b0, rd, selIdx, kSeen, aSeen, lat);
      check("R2", "removed fn0 rdata", rd, ONES);
      check("R2", "removed fn0 slot", 32'(selIdx), 32'hFFFF_FFFF);
      slotPresent[8] = 1'b1;
    end

    // R7: reserved kind 3 is never claimed
    begin
      logic [31:0] rd, aSeen; logic [1:0] kSeen; int selIdx, lat;
      doReq(2'd3, 32'h1000_0040, 1'b0, rd, selIdx, kSeen, aSeen, lat);
      check("R7", "reserved kind rdata", rd, ONES);
      check("R7", "reserved kind latency", 32'(lat), 32'd18);
    end

    // R8: slot1 silent times out after being selected
    begin
      logic [31:0] rd, aSeen; logic [1:0] kSeen; int selIdx, lat;
      ackEn = 4'b0101;
      doReq(2'd2, 32'h0000_0800, 1'b0, rd, selIdx, kSeen, aSeen, lat);
      check("R8", "silent cfg rdata", rd, ONES);
      check("R8", "silent cfg slot", 32'(selIdx), 32'd1);
      check("R8", "deselected after timeout", 32'(slotSel), 32'd0);
      ackEn = 4'b0111;
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule